// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block is the transmit side of a network controller's DMA. Software places fixed-size 8-byte descriptors in a circular ring in memory. Each descriptor points at one fragment of an outgoing frame. A kick strobe starts a pass. In that pass the engine fetches descriptors from its current ring position and copies the bytes of each valid fragment into an internal gather buffer. When it reaches a fragment flagged as the end of a frame, it streams the whole frame out one byte per cycle, with the final byte marked. Every descriptor it consumes is written back so that software can reclaim it.

A pass ends at the first descriptor that is not valid, or after one complete frame, or after one full lap of the ring. A frame may span several passes: gathered fragments stay in the buffer until their closing fragment arrives. Memory is reached through a word-wide read port and a word-wide write port, each using a request/acknowledge handshake. When a pass that sent a frame finishes, a one-cycle completion pulse goes to the interrupt logic. A level output reports when the engine is idle.

Top module: `txg_engine`

## Requirements
- R1: After reset the engine is idle (`eng_idle`=1). It issues no memory request, emits no stream byte, and holds `done_irq` and `ovf_err` low.
- R2: Descriptor number i sits at `ring_base + 8*i`. The read word at offset 0 is the buffer address. The read word at offset 4 holds the length field in bits [15:0] and the flags in bits [31:16]. The read port returns the bytes at `rd_addr`..`rd_addr+3`, with the lowest address in bits [7:0]. After entry `ring_last` the index goes back to 0. If the index is above `ring_last` when a pass starts, the pass begins at entry 0.
- R3: A descriptor whose valid flag (flags bit 15) is clear ends the pass. It is not written back and none of its buffer bytes are read. A pass examines at most `ring_last`+1 descriptors.
- R4: Each valid fragment contributes length field + 1 bytes, taken in address order. These are appended after the bytes already gathered. The frame leaves on `tx_data` at one byte per cycle while `tx_valid` is high, and `tx_last` marks its final byte.
- R5: Every consumed descriptor gets a single write to its offset 4. In that word, bits [15:0] hold the length field + 5, and bits [31:16] hold the flags with bits 3, 10, 11, 12, 13, 14 and 15 cleared and all other bits kept. A closing fragment is written back only after its frame has been fully emitted.
- R6: A descriptor carrying the last-fragment flag (flags bit 0) ends the pass once its write-back is done. The next pass starts at the entry after it.
- R7: `eng_idle` drops in the cycle after an accepted kick and rises again when the pass ends. A kick that arrives during a pass is ignored.
- R8: `done_irq` pulses for exactly one cycle at the end of a pass in which a frame was emitted, and at no other time.
- R9: Fragments gathered without a closing fragment stay buffered across passes. The next pass appends to them.
- R10: A fragment that would push the gathered total above `BUF_BYTES` raises `ovf_err` for one cycle, and its buffer is not read. The partial frame is discarded. Later fragments up to and including the closing one are also discarded, but their descriptors are still written back. No frame is emitted for them.
- R11: `ring_clear` while idle sets the ring index to 0 and discards any partial frame. If it arrives together with a kick, the kick is dropped.
- R12: Once a memory request is raised, it stays raised, with its address and write data unchanged, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Start-of-pass strobe |
| ring_clear | input | 1 | Return ring index to 0 and drop partial frame (idle only) |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| ring_last | input | IDX_W | Number of ring entries minus one |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid in the same cycle |
| rd_data | input | 32 | Four bytes starting at `rd_addr`, little-endian |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write data (descriptor word at offset 4) |
| wr_ack | input | 1 | Write acknowledge |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| eng_idle | output | 1 | High when no pass is running |
| done_irq | output | 1 | One-cycle pulse: pass ended with a frame sent |
| ovf_err | output | 1 | One-cycle pulse: fragment overflowed the gather buffer |

## Verification
A wrong ring index shows up at the next descriptor fetch. The read address is then off by a multiple of 8, and the write-back lands on the wrong entry, within a few cycles of the kick. A wrong gather offset stays hidden until the closing fragment. At that point the streamed frame has the wrong length, or bytes in the wrong place, so the bench compares every emitted byte and every write-back word against a queue built from the descriptors it placed in memory. Scan-limit and stop-after-last errors show up as unexpected extra reads or write-backs. To catch them, the bench leaves stale valid descriptors in memory on purpose and counts read handshakes per pass.

// File: rtl/txg_pkg.sv
`timescale 1ns/1ps
package txg_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned LANES     = WORD_W / 8;
   localparam int unsigned DESC_SZ   = 8;

   // flag bit positions inside the descriptor flags half-word
   localparam int unsigned FLG_LAST  = 0;
   localparam int unsigned FLG_VALID = 15;

   // flags cleared on write-back: bits 3, 10..15
   localparam logic [15:0] WB_CLEAR  = 16'hFC08;
   localparam logic [15:0] LEN_BUMP  = 16'd5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DESC_ADDR,
      ST_DESC_CTRL,
      ST_PULL,
      ST_EMIT,
      ST_WRITEBACK,
      ST_FINISH
   } walk_state_e;

endpackage

// File: rtl/txg_gather_buf.sv
`timescale 1ns/1ps
module txg_gather_buf #(
   parameter int DEPTH  = 256,
   parameter int PTR_W  = $clog2(DEPTH),
   parameter int BASE_W = $clog2(DEPTH + 1),
   parameter int LANES  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LANES-1:0]     wr_en,
   input  logic [BASE_W-1:0]    wr_base,
   input  logic [LANES*8-1:0]   wr_data,
   input  logic [PTR_W-1:0]     rd_addr,
   output logic [7:0]           rd_data
);

   localparam int SUM_W = BASE_W + 1;

   if (DEPTH < LANES) begin : g_bad_depth
      $error("txg_gather_buf: DEPTH must be at least LANES");
   end
   if ((1 << PTR_W) < DEPTH) begin : g_bad_ptr
      $error("txg_gather_buf: PTR_W too narrow for DEPTH");
   end

   logic [7:0]       store [DEPTH];
   logic [PTR_W-1:0] lane_addr [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [SUM_W-1:0] lane_sum;
      assign lane_sum     = SUM_W'(wr_base) + SUM_W'(k);
      assign lane_addr[k] = PTR_W'(lane_sum);

      // no lane may write beyond the end of the buffer
      p_no_overflow_r10 : assert property (@(posedge clk) disable iff (!rst_n)
         wr_en[k] |-> (lane_sum < SUM_W'(DEPTH)));
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (wr_en[k]) store[lane_addr[k]] <= wr_data[k*8 +: 8];
      end
   end

   assign rd_data = store[rd_addr];

endmodule

// File: rtl/txg_frame_out.sv
`timescale 1ns/1ps
module txg_frame_out #(
   parameter int OFS_W = 9,
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OFS_W-1:0] frame_len,
   output logic [PTR_W-1:0] buf_addr,
   input  logic [7:0]       buf_data,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   output logic             done
);

   logic             active;
   logic [OFS_W-1:0] cnt;
   logic             at_end;

   assign buf_addr = cnt[PTR_W-1:0];
   assign at_end   = (cnt == frame_len - OFS_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cnt      <= '0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
         tx_last  <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (active) begin
            tx_valid <= 1'b1;
            tx_data  <= buf_data;
            tx_last  <= at_end;
            cnt      <= cnt + OFS_W'(1);
            if (at_end) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end else begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
         end
         if (start) begin
            active <= 1'b1;
            cnt    <= '0;
         end
      end
   end

   p_last_marks_byte_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   p_done_on_last_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> tx_last);

endmodule

// File: rtl/txg_engine.sv
`timescale 1ns/1ps
module txg_engine
   import txg_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 8,
   parameter int BUF_BYTES = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick,
   input  logic              ring_clear,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [IDX_W-1:0]  ring_last,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [31:0]       rd_data,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   input  logic              wr_ack,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic              eng_idle,
   output logic              done_irq,
   output logic              ovf_err
);

   localparam int OFS_W  = $clog2(BUF_BYTES + 1);
   localparam int PTR_W  = $clog2(BUF_BYTES);
   localparam int NEED_W = 17;
   localparam int TOT_W  = NEED_W + 1;
   localparam int CNT_W  = IDX_W + 1;

   if (BUF_BYTES < int'(LANES) || BUF_BYTES > 65536) begin : g_bad_buf
      $error("txg_engine: BUF_BYTES out of range");
   end
   if (ADDR_W < IDX_W + 3 || ADDR_W > 32) begin : g_bad_addr
      $error("txg_engine: ADDR_W must hold the ring and fit the data word");
   end

   walk_state_e        state;
   logic [IDX_W-1:0]   idx;
   logic [CNT_W-1:0]   scanned;
   logic               sent;
   logic               drop;
   logic [OFS_W-1:0]   gofs;
   logic [ADDR_W-1:0]  frag_ptr;
   logic [NEED_W-1:0]  remain;
   logic [15:0]        dlen;
   logic [15:0]        dflags;
   logic               send_go;
   logic               err_r;

   logic [ADDR_W-1:0]  desc_addr;
   logic [NEED_W-1:0]  need_c;
   logic [TOT_W-1:0]   tot_c;
   logic [2:0]         take;
   logic               pull_fire;
   logic [LANES-1:0]   lane_en;
   logic               scan_full;
   logic [IDX_W-1:0]   idx_next;
   logic [PTR_W-1:0]   out_addr;
   logic [7:0]         out_byte;
   logic               frame_done;

   // ---------------- address and fragment arithmetic ----------------
   assign desc_addr = ring_base + (ADDR_W'(idx) << 3);
   assign need_c    = {1'b0, rd_data[15:0]} + NEED_W'(1);
   assign tot_c     = TOT_W'(gofs) + TOT_W'(need_c);
   assign take      = (remain >= NEED_W'(LANES)) ? 3'(LANES) : remain[2:0];
   assign pull_fire = (state == ST_PULL) && rd_ack;
   assign scan_full = (scanned == (CNT_W'(ring_last) + CNT_W'(1)));
   assign idx_next  = (idx == ring_last) ? '0 : idx + IDX_W'(1);

   for (genvar k = 0; k < int'(LANES); k++) begin : g_lane_en
      assign lane_en[k] = pull_fire && (3'(k) < take);
   end

   // ---------------- memory port requests ----------------
   always_comb begin
      rd_req  = 1'b0;
      rd_addr = desc_addr;
      case (state)
         ST_DESC_ADDR: rd_req = 1'b1;
         ST_DESC_CTRL: begin
            rd_req  = 1'b1;
            rd_addr = desc_addr + ADDR_W'(4);
         end
         ST_PULL: begin
            rd_req  = 1'b1;
            rd_addr = frag_ptr;
         end
         default: ;
      endcase
   end

   assign wr_req   = (state == ST_WRITEBACK);
   assign wr_addr  = desc_addr + ADDR_W'(4);
   assign wr_data  = {dflags & ~WB_CLEAR, dlen + LEN_BUMP};
   assign eng_idle = (state == ST_IDLE);
   assign done_irq = (state == ST_FINISH) && sent;
   assign ovf_err  = err_r;

   // ---------------- ring walker ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         scanned  <= '0;
         sent     <= 1'b0;
         drop     <= 1'b0;
         gofs     <= '0;
         frag_ptr <= '0;
         remain   <= '0;
         dlen     <= '0;
         dflags   <= '0;
         send_go  <= 1'b0;
         err_r    <= 1'b0;
      end else begin
         send_go <= 1'b0;
         err_r   <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (ring_clear) begin
                  idx  <= '0;
                  gofs <= '0;
                  drop <= 1'b0;
               end else if (kick) begin
                  sent    <= 1'b0;
                  scanned <= '0;
                  if (idx > ring_last) idx <= '0;
                  state   <= ST_DESC_ADDR;
               end
            end
            ST_DESC_ADDR: begin
               if (rd_ack) begin
                  frag_ptr <= ADDR_W'(rd_data);
                  state    <= ST_DESC_CTRL;
               end
            end
            ST_DESC_CTRL: begin
               if (rd_ack) begin
                  dlen    <= rd_data[15:0];
                  dflags  <= rd_data[31:16];
                  scanned <= scanned + CNT_W'(1);
                  if (!rd_data[16 + FLG_VALID]) begin
                     state <= ST_FINISH;
                  end else if (drop) begin
                     state <= ST_WRITEBACK;
                  end else if (tot_c > TOT_W'(BUF_BYTES)) begin
                     err_r <= 1'b1;
                     gofs  <= '0;
                     drop  <= 1'b1;
                     state <= ST_WRITEBACK;
                  end else begin
                     remain <= need_c;
                     state  <= ST_PULL;
                  end
               end
            end
            ST_PULL: begin
               if (rd_ack) begin
                  gofs     <= gofs + OFS_W'(take);
                  remain   <= remain - NEED_W'(take);
                  frag_ptr <= frag_ptr + ADDR_W'(LANES);
                  if (remain == NEED_W'(take)) begin
                     if (dflags[FLG_LAST]) begin
                        send_go <= 1'b1;
                        state   <= ST_EMIT;
                     end else begin
                        state <= ST_WRITEBACK;
                     end
                  end
               end
            end
            ST_EMIT: begin
               if (frame_done) begin
                  gofs  <= '0;
                  sent  <= 1'b1;
                  state <= ST_WRITEBACK;
               end
            end
            ST_WRITEBACK: begin
               if (wr_ack) begin
                  idx <= idx_next;
                  if (dflags[FLG_LAST]) begin
                     drop  <= 1'b0;
                     state <= ST_FINISH;
                  end else if (scan_full) begin
                     state <= ST_FINISH;
                  end else begin
                     state <= ST_DESC_ADDR;
                  end
               end
            end
            ST_FINISH: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   // ---------------- storage and output stream ----------------
   txg_gather_buf #(
      .DEPTH  (BUF_BYTES),
      .PTR_W  (PTR_W),
      .BASE_W (OFS_W),
      .LANES  (int'(LANES))
   ) i_gbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lane_en),
      .wr_base (gofs),
      .wr_data (rd_data),
      .rd_addr (out_addr),
      .rd_data (out_byte)
   );

   txg_frame_out #(
      .OFS_W (OFS_W),
      .PTR_W (PTR_W)
   ) i_fout (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (send_go),
      .frame_len (gofs),
      .buf_addr  (out_addr),
      .buf_data  (out_byte),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_last   (tx_last),
      .done      (frame_done)
   );

   // ---------------- assertions ----------------
   p_rd_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   p_wr_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   p_stream_in_pass_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !eng_idle);

   p_kick_starts_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (kick && !ring_clear && eng_idle) |=> !eng_idle);

   p_irq_single_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> (eng_idle && !done_irq));

   p_stop_after_last_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_ack && wr_data[16 + FLG_LAST]) |=> (!rd_req && !wr_req));

   p_valid_cleared_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !wr_data[16 + FLG_VALID]);

endmodule

// File: tb/test_txg_engine.sv
`timescale 1ns/1ps
module test_txg_engine;

   localparam int          ADDR_W    = 32;
   localparam int          IDX_W     = 8;
   localparam int          BUF_BYTES = 256;
   localparam logic [31:0] RING      = 32'h100;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              kick, ring_clear;
   logic [ADDR_W-1:0] ring_base;
   logic [IDX_W-1:0]  ring_last;
   logic              rd_req, rd_ack;
   logic [ADDR_W-1:0] rd_addr;
   logic [31:0]       rd_data;
   logic              wr_req, wr_ack;
   logic [ADDR_W-1:0] wr_addr;
   logic [31:0]       wr_data;
   logic              tx_valid, tx_last;
   logic [7:0]        tx_data;
   logic              eng_idle, done_irq, ovf_err;

   always #4 clk = ~clk;   // 125 MHz

   txg_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) i_txg_engine (
      .clk(clk), .rst_n(rst_n), .kick(kick), .ring_clear(ring_clear),
      .ring_base(ring_base), .ring_last(ring_last),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .eng_idle(eng_idle), .done_irq(done_irq), .ovf_err(ovf_err)
   );

   logic [7:0]  mem [4096];
   logic [8:0]  exp_q [$];
   logic [63:0] wb_q  [$];
   logic [7:0]  pend  [$];
   int n_chk = 0, n_fail = 0;
   int irq_cnt = 0, err_cnt = 0, rd_cnt = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_word(input logic [31:0] a);
      return {mem[12'(a + 3)], mem[12'(a + 2)], mem[12'(a + 1)], mem[12'(a)]};
   endfunction

   task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
      for (int k = 0; k < 4; k++) mem[12'(a + k)] = d[k*8 +: 8];
   endtask

   task automatic tick;
      @(negedge clk);
      #1;
   endtask

   // driver: place a descriptor, fill its buffer, push expected items
   task automatic put_desc(input int slot, input logic [31:0] bufa, input int lenf,
                           input logic [15:0] flg, input int seed,
                           input bit emit, input bit want_wb);
      logic [31:0] da;
      da = RING + 32'(slot * 8);
      wr_word(da, bufa);
      wr_word(da + 4, {flg, 16'(lenf)});
      if (flg[15]) begin
         for (int i = 0; i <= lenf; i++) begin
            logic [7:0] b;
            b = 8'(seed + i * 7);
            mem[12'(bufa + 32'(i))] = b;
            if (emit) pend.push_back(b);
         end
      end
      if (emit && flg[0]) begin
         for (int j = 0; j < pend.size(); j++)
            exp_q.push_back({(j == pend.size() - 1), pend[j]});
         pend.delete();
      end
      if (want_wb)
         wb_q.push_back({da + 32'd4, flg & ~16'hFC08, 16'(lenf + 5)});
   endtask

   task automatic run_pass(input string req);
      int g;
      tick; kick = 1'b1;
      tick; kick = 1'b0;
      check(!eng_idle, "R7", "idle not dropped after kick", 64'(eng_idle), 0);
      g = 0;
      while (!eng_idle && g < 5000) begin tick; g++; end
      repeat (3) tick;
      check(exp_q.size() == 0, req, "frame bytes not emitted", 64'(exp_q.size()), 0);
      check(wb_q.size() == 0, req, "write-backs missing", 64'(wb_q.size()), 0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      int irq0, err0, rd0;
      kick = 0; ring_clear = 0; ring_base = RING; ring_last = 3;
      rd_ack = 0; rd_data = '0; wr_ack = 0; rst_n = 0;
      for (int i = 0; i < 4096; i++) mem[i] = '0;

      fork
         begin : watchdog
            repeat (150000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary;
            $finish;
         end
         begin : responder_monitor
            int rc, wc, rlat, wlat;
            logic [31:0] rseen, wseen;
            rc = 0; wc = 0; rlat = 0; wlat = 1; rseen = '0; wseen = '0;
            forever begin
               @(negedge clk);
               if (!rst_n) begin
                  rd_ack = 0; wr_ack = 0; rc = 0; wc = 0;
               end else begin
                  if (rd_ack) begin rd_ack = 0; rc = 0; end
                  else if (rd_req) begin
                     if (rc == 0) rseen = rd_addr;
                     if (rc >= rlat) begin
                        check(rd_addr == rseen, "R12", "read addr moved", 64'(rd_addr), 64'(rseen));
                        rd_data = rd_word(rd_addr);
                        rd_ack = 1; rd_cnt++; rlat = (rlat + 1) % 4;
                     end
                     rc++;
                  end
                  if (wr_ack) begin wr_ack = 0; wc = 0; end
                  else if (wr_req) begin
                     if (wc == 0) wseen = wr_addr;
                     if (wc >= wlat) begin
                        check(wr_addr == wseen, "R12", "write addr moved", 64'(wr_addr), 64'(wseen));
                        wr_ack = 1; wlat = (wlat + 1) % 3;
                        if (wb_q.size() == 0)
                           check(0, "R5", "unexpected write-back", {wr_addr, wr_data}, 0);
                        else begin
                           logic [63:0] e;
                           e = wb_q.pop_front();
                           check({wr_addr, wr_data} == e, "R5", "write-back addr/data",
                                 {wr_addr, wr_data}, e);
                        end
                     end
                     wc++;
                  end
                  if (tx_valid) begin
                     if (exp_q.size() == 0)
                        check(0, "R4", "unexpected stream byte", {tx_last, tx_data}, 0);
                     else begin
                        logic [8:0] e;
                        e = exp_q.pop_front();
                        check({tx_last, tx_data} == e, "R4", "stream byte/last",
                              64'({tx_last, tx_data}), 64'(e));
                     end
                  end
                  if (done_irq) irq_cnt++;
                  if (ovf_err)  err_cnt++;
               end
            end
         end
      join_none

      // R1 reset state
      repeat (3) tick;
      check(eng_idle && !rd_req && !wr_req && !tx_valid && !done_irq && !ovf_err,
            "R1", "state in reset", {eng_idle, rd_req, wr_req, tx_valid, done_irq, ovf_err}, 6'b100000);
      rst_n = 1;
      repeat (2) tick;
      check(eng_idle && !rd_req && !wr_req && !tx_valid, "R1", "state after reset",
            {eng_idle, rd_req, wr_req, tx_valid}, 4'b1000);

      // T2: single-fragment frame in slot 0 (R2, R4, R5, R8)
      irq0 = irq_cnt;
      put_desc(0, 32'h400, 9, 16'h8001, 16'h10, 1, 1);
      run_pass("R4");
      check(irq_cnt - irq0 == 1, "R8", "irq after frame", 64'(irq_cnt - irq0), 1);

      // T3: three fragments, unaligned, error bits; slot0 valid but must be untouched (R6)
      irq0 = irq_cnt;
      put_desc(0, 32'h480, 5, 16'h8001, 16'h99, 0, 0);
      put_desc(1, 32'h501, 2, 16'hFD08, 16'h21, 1, 1);
      put_desc(2, 32'h523, 4, 16'h8000, 16'h42, 1, 1);
      put_desc(3, 32'h546, 0, 16'h8001, 16'h63, 1, 1);
      run_pass("R6");
      check(irq_cnt - irq0 == 1, "R8", "one irq for gathered frame", 64'(irq_cnt - irq0), 1);

      // T4: index wrapped to slot 0 (R2)
      put_desc(0, 32'h480, 5, 16'h8001, 16'h99, 1, 1);
      run_pass("R2");

      // T5: invalid descriptor ends pass with no data reads (R3)
      irq0 = irq_cnt; rd0 = rd_cnt;
      put_desc(1, 32'h5A0, 3, 16'h0001, 16'h11, 0, 0);
      run_pass("R3");
      check(rd_cnt - rd0 == 2, "R3", "reads for invalid descriptor", 64'(rd_cnt - rd0), 2);
      check(irq_cnt - irq0 == 0, "R8", "no irq without frame", 64'(irq_cnt - irq0), 0);

      // T6: partial frame survives across passes (R9)
      irq0 = irq_cnt;
      put_desc(1, 32'h600, 6, 16'h8000, 16'h30, 1, 1);
      put_desc(2, 32'h680, 3, 16'h0000, 16'h00, 0, 0);
      run_pass("R9");
      check(irq_cnt - irq0 == 0, "R8", "no irq for partial", 64'(irq_cnt - irq0), 0);
      put_desc(2, 32'h680, 3, 16'h8001, 16'h50, 1, 1);
      run_pass("R9");
      check(irq_cnt - irq0 == 1, "R8", "irq on completion", 64'(irq_cnt - irq0), 1);

      // T7: ring of 2, index 3 clamps to 0, scan limit (R2, R3), then clear (R11)
      ring_last = 1;
      irq0 = irq_cnt; rd0 = rd_cnt;
      put_desc(0, 32'h700, 1, 16'h8000, 16'h61, 1, 1);
      put_desc(1, 32'h710, 2, 16'h8000, 16'h71, 1, 1);
      run_pass("R3");
      check(rd_cnt - rd0 == 6, "R3", "reads with scan limit", 64'(rd_cnt - rd0), 6);
      check(irq_cnt - irq0 == 0, "R8", "no irq at scan limit", 64'(irq_cnt - irq0), 0);
      pend.delete();
      tick; ring_clear = 1; kick = 1;
      tick; ring_clear = 0; kick = 0;
      tick;
      check(eng_idle, "R11", "kick with clear dropped", 64'(eng_idle), 1);
      put_desc(0, 32'h720, 3, 16'h8001, 16'h81, 1, 1);
      run_pass("R11");

      // T8: gather overflow (R10)
      ring_last = 3;
      irq0 = irq_cnt; err0 = err_cnt; rd0 = rd_cnt;
      put_desc(1, 32'h800, 199, 16'h8000, 16'h05, 0, 1);
      put_desc(2, 32'h900, 99,  16'h8000, 16'h06, 0, 1);
      put_desc(3, 32'h980, 5,   16'h8001, 16'h07, 0, 1);
      run_pass("R10");
      check(err_cnt - err0 == 1, "R10", "overflow pulse", 64'(err_cnt - err0), 1);
      check(irq_cnt - irq0 == 0, "R10", "no frame after overflow", 64'(irq_cnt - irq0), 0);
      check(rd_cnt - rd0 == 56, "R10", "overflowing buffer not read", 64'(rd_cnt - rd0), 56);
      put_desc(0, 32'hA00, 3, 16'h8001, 16'h90, 1, 1);
      run_pass("R10");

      // T9: exactly full buffer is accepted (R10 boundary)
      err0 = err_cnt;
      put_desc(1, 32'hB00, 255, 16'h8001, 16'h33, 1, 1);
      run_pass("R4");
      check(err_cnt - err0 == 0, "R10", "full-size frame no error", 64'(err_cnt - err0), 0);

      // T10: kick during a pass is ignored (R7)
      irq0 = irq_cnt;
      put_desc(2, 32'hC00, 2, 16'h8001, 16'hA1, 1, 1);
      put_desc(3, 32'hC10, 2, 16'h8001, 16'hB1, 0, 0);
      tick; kick = 1;
      tick; kick = 0;
      tick; tick; kick = 1;
      tick; kick = 0;
      while (!eng_idle) tick;
      repeat (20) tick;
      check(eng_idle, "R7", "stays idle after busy kick", 64'(eng_idle), 1);
      check(exp_q.size() == 0 && wb_q.size() == 0, "R7", "single pass only",
            64'(exp_q.size() + wb_q.size()), 0);
      check(irq_cnt - irq0 == 1, "R7", "one irq for one pass", 64'(irq_cnt - irq0), 1);

      summary;
      $finish;
   end

endmodule